// File: doc/BRIEF.md
# Video Control Register Bank with Retrace Interlock

This block holds the 32-bit control registers of a video and tile-accelerator core. A simple register bus drives it: a word address, write data, a write enable and a read data return. Each writable location clears the bits it does not implement before it stores a value. Five locations are status views fed from input ports, and writes to them are dropped. Two locations are command triggers. A write to one of them emits a one-cycle pulse and stores nothing, but only when the written value matches that trigger's qualifying pattern.

A small two-state machine holds a pending flip. It has the states `RT_IDLE` and `RT_PENDING`. The transition ARM (`RT_IDLE` to `RT_PENDING`) is taken on a `vblank` pulse. The transition FLIP (`RT_PENDING` to `RT_IDLE`) is taken on a write to the frame-address register, and it emits `frame_flip`. The state holds on any other input: HOLD_IDLE and HOLD_PENDING. The two 10-bit vertical line compare values are taken from their register and driven on their own ports, so the interrupt logic can use them directly.

Top module: `vidctl_regbank`

## Requirements
- R1: A synchronous active-high `rst` clears every stored register to zero. It also returns the interlock to `RT_IDLE` and drives all three pulse outputs low.
- R2: A write to word 5 (draw trigger) pulses `draw_go` for one cycle after the write edge, but only when the data is 0xFFFFFFFF. Any other value has no effect. Word 5 reads back 0.
- R3: A write to word 6 (engine init) pulses `eng_init` for one cycle after the write edge, but only when data bit 31 is 1. Word 6 reads back 0.
- R4: Word 7 (frame address) stores data & 0x00FFFFFC.
- R5: In `RT_PENDING`, a write to word 7 raises `frame_flip` for one cycle and returns to `RT_IDLE`, even when `vblank` is high in the same cycle. In `RT_IDLE`, a write to word 7 does not flip. In `RT_IDLE`, a `vblank` arms the interlock, even when word 7 is written in the same cycle.
- R6: Word 8 (horizontal window) stores data & 0x07FF07FF. Word 9 (vertical window) stores data & 0x03FF03FF. Word 10 (horizontal IRQ position) stores data & 0x03FF33FF.
- R7: Word 11 (vertical IRQ lines) stores data & 0x03FF03FF. `vline_cmp_a` is stored bits 25:16 and `vline_cmp_b` is stored bits 9:0. Both change only after a write to word 11 or after a reset.
- R8: Words 12, 13 and 14 (bin start, bin stop, link start) store data & 0x00FFFFE0. Words 15 and 16 (primitive start and stop) store data & 0x00FFFFFC.
- R9: Word 17 (bin dimensions) stores data & 0x000F003F. Word 18 (bin config) stores data & 0x00133333.
- R10: Words 19 to 31 store all 32 written bits unchanged.
- R11: Words 0 to 4 read `id_val`, `rev_val`, `beam_val`, `prim_pos_val` and `link_pos_val` in that order. Writes to these words change nothing.
- R12: The block registers `bus_addr` at each clock edge, and `bus_rdata` shows the selected word after that edge. A write to the same word at the same edge is already visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address for read and write |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address registered at the last edge |
| id_val | input | 32 | Value returned by word 0 |
| rev_val | input | 32 | Value returned by word 1 |
| beam_val | input | 32 | Value returned by word 2 |
| prim_pos_val | input | 32 | Value returned by word 3 |
| link_pos_val | input | 32 | Value returned by word 4 |
| vblank | input | 1 | Vertical blank pulse that arms the flip interlock |
| draw_go | output | 1 | One-cycle draw command pulse |
| eng_init | output | 1 | One-cycle engine init pulse |
| frame_flip | output | 1 | One-cycle display flip pulse |
| vline_cmp_a | output | 10 | Vertical IRQ compare value, stored bits 25:16 |
| vline_cmp_b | output | 10 | Vertical IRQ compare value, stored bits 9:0 |

## Verification
The bench writes near-miss values to both triggers: 0xFFFFFFFE to the draw trigger and 0x7FFFFFFF to the init trigger. A decode that tested too few bits would pulse on these. It writes the frame address with `vblank` high in both interlock states. A design with the wrong priority would flip on the first write after blanking, or drop a pending flip. Every masked register gets all ones, so a mask with a wrong bit shows up on read-back. Writes to the status words check that a write cannot overwrite a port-driven value. A write and a read of the same word at one edge expose an extra cycle of read latency.

// File: rtl/vidctl_pkg.sv
package vidctl_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        K_PLAIN,
        K_RO,
        K_TRIG,
        K_MASK
    } reg_kind_e;

    typedef enum logic {
        RT_IDLE,
        RT_PENDING
    } rt_state_e;

    localparam int A_CHIP_ID    = 0;
    localparam int A_REV        = 1;
    localparam int A_BEAM       = 2;
    localparam int A_PRIM_POS   = 3;
    localparam int A_LINK_POS   = 4;
    localparam int A_DRAW_GO    = 5;
    localparam int A_ENG_INIT   = 6;
    localparam int A_FB_ADDR    = 7;
    localparam int A_HWIN       = 8;
    localparam int A_VWIN       = 9;
    localparam int A_HIRQ       = 10;
    localparam int A_VIRQ       = 11;
    localparam int A_BIN_START  = 12;
    localparam int A_BIN_STOP   = 13;
    localparam int A_LINK_START = 14;
    localparam int A_PRIM_START = 15;
    localparam int A_PRIM_STOP  = 16;
    localparam int A_BIN_DIM    = 17;
    localparam int A_BIN_CFG    = 18;

    localparam int MIN_ADDR_W   = 5;

    function automatic reg_kind_e kind_of(input int idx);
        reg_kind_e k;
        if (idx <= A_LINK_POS)
            k = K_RO;
        else if (idx == A_DRAW_GO || idx == A_ENG_INIT)
            k = K_TRIG;
        else if (idx <= A_BIN_CFG)
            k = K_MASK;
        else
            k = K_PLAIN;
        return k;
    endfunction

    function automatic logic [WORD_W-1:0] mask_of(input int idx);
        logic [WORD_W-1:0] m;
        case (idx)
            A_FB_ADDR, A_PRIM_START, A_PRIM_STOP: m = 32'h00FF_FFFC;
            A_HWIN:                               m = 32'h07FF_07FF;
            A_VWIN, A_VIRQ:                       m = 32'h03FF_03FF;
            A_HIRQ:                               m = 32'h03FF_33FF;
            A_BIN_START, A_BIN_STOP, A_LINK_START: m = 32'h00FF_FFE0;
            A_BIN_DIM:                            m = 32'h000F_003F;
            A_BIN_CFG:                            m = 32'h0013_3333;
            default:                              m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/vidctl_wmask.sv
module vidctl_wmask
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 5,
    localparam int NREG = 1 << ADDR_W
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [NREG-1:0]   store_hit,
    output logic [WORD_W-1:0] store_val
);

    // Only plain and masked words own storage; status and trigger words never load.
    for (genvar i = 0; i < NREG; i++) begin : g_dec
        localparam reg_kind_e KIND = kind_of(i);
        if (KIND == K_PLAIN || KIND == K_MASK) begin : g_store
            assign store_hit[i] = wr_en && (wr_addr == ADDR_W'(i));
        end else begin : g_drop
            assign store_hit[i] = 1'b0;
        end
    end

    assign store_val = wr_data & mask_of(int'(wr_addr));

endmodule

// File: rtl/vidctl_trigger.sv
module vidctl_trigger
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic              draw_go,
    output logic              eng_init
);

    logic draw_cmd;
    logic init_cmd;

    always_comb begin
        draw_cmd = wr_en && (wr_addr == ADDR_W'(A_DRAW_GO)) && (wr_data == '1);
        init_cmd = wr_en && (wr_addr == ADDR_W'(A_ENG_INIT)) && wr_data[WORD_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            draw_go  <= 1'b0;
            eng_init <= 1'b0;
        end else begin
            draw_go  <= draw_cmd;
            eng_init <= init_cmd;
        end
    end

    assert_draw_magic_R2: assert property (@(posedge clk) disable iff (rst)
        draw_go |-> $past(wr_en && wr_addr == ADDR_W'(A_DRAW_GO) && wr_data == 32'hFFFF_FFFF));

    assert_init_bit31_R3: assert property (@(posedge clk) disable iff (rst)
        eng_init |-> $past(wr_en && wr_addr == ADDR_W'(A_ENG_INIT) && wr_data[31]));

    assert_one_cmd_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({draw_go, eng_init}));

endmodule

// File: rtl/vidctl_retrace.sv
module vidctl_retrace
    import vidctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vblank,
    input  logic fb_wr,
    output logic frame_flip
);

    rt_state_e state;
    rt_state_e state_nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state <= RT_IDLE;
        else
            state <= state_nxt;
    end

    // Transitions: ARM, FLIP, HOLD_IDLE, HOLD_PENDING.
    always_comb begin
        state_nxt = state;
        unique case (state)
            RT_IDLE:    state_nxt = vblank ? RT_PENDING : RT_IDLE;
            RT_PENDING: state_nxt = fb_wr  ? RT_IDLE    : RT_PENDING;
            default:    state_nxt = RT_IDLE;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (rst)
            frame_flip <= 1'b0;
        else
            frame_flip <= (state == RT_PENDING) && fb_wr;
    end

    assert_flip_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RT_PENDING && fb_wr) |=> (frame_flip && state == RT_IDLE));

    assert_no_flip_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RT_IDLE) |=> !frame_flip);

    assert_vblank_arms_R5: assert property (@(posedge clk) disable iff (rst)
        (state == RT_IDLE && vblank) |=> (state == RT_PENDING));

endmodule

// File: rtl/vidctl_regbank.sv
module vidctl_regbank
    import vidctl_pkg::*;
#(
    parameter int ADDR_W = 5  // must be at least MIN_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       id_val,
    input  logic [31:0]       rev_val,
    input  logic [31:0]       beam_val,
    input  logic [31:0]       prim_pos_val,
    input  logic [31:0]       link_pos_val,
    input  logic              vblank,
    output logic              draw_go,
    output logic              eng_init,
    output logic              frame_flip,
    output logic [9:0]        vline_cmp_a,
    output logic [9:0]        vline_cmp_b
);

    localparam int NREG = 1 << ADDR_W;

    logic [NREG-1:0]   store_hit;
    logic [WORD_W-1:0] store_val;
    logic [WORD_W-1:0] regs [NREG];
    logic [ADDR_W-1:0] addr_q;
    logic              fb_wr;
    logic              past_ok;

    vidctl_wmask #(.ADDR_W(ADDR_W)) u_wmask (
        .wr_en     (bus_we),
        .wr_addr   (bus_addr),
        .wr_data   (bus_wdata),
        .store_hit (store_hit),
        .store_val (store_val)
    );

    vidctl_trigger #(.ADDR_W(ADDR_W)) u_trig (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_we),
        .wr_addr  (bus_addr),
        .wr_data  (bus_wdata),
        .draw_go  (draw_go),
        .eng_init (eng_init)
    );

    assign fb_wr = bus_we && (bus_addr == ADDR_W'(A_FB_ADDR));

    vidctl_retrace u_retrace (
        .clk        (clk),
        .rst        (rst),
        .vblank     (vblank),
        .fb_wr      (fb_wr),
        .frame_flip (frame_flip)
    );

    // Register storage and registered read address.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else begin
            addr_q <= bus_addr;
            for (int i = 0; i < NREG; i++)
                if (store_hit[i]) regs[i] <= store_val;
        end
    end

    // Read selection.
    always_comb begin
        bus_rdata = '0;
        unique case (kind_of(int'(addr_q)))
            K_RO: begin
                case (int'(addr_q))
                    A_CHIP_ID:  bus_rdata = id_val;
                    A_REV:      bus_rdata = rev_val;
                    A_BEAM:     bus_rdata = beam_val;
                    A_PRIM_POS: bus_rdata = prim_pos_val;
                    default:    bus_rdata = link_pos_val;
                endcase
            end
            K_TRIG:         bus_rdata = '0;
            K_PLAIN, K_MASK: bus_rdata = regs[addr_q];
            default:        bus_rdata = '0;
        endcase
    end

    assign vline_cmp_a = regs[A_VIRQ][25:16];
    assign vline_cmp_b = regs[A_VIRQ][9:0];

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assert_virq_hold_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(bus_we && bus_addr == ADDR_W'(A_VIRQ)) |-> ($stable(vline_cmp_a) && $stable(vline_cmp_b)));

    assert_trig_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_we) |-> (!draw_go && !eng_init && !frame_flip));

endmodule

// File: tb/vidctl_regbank_test.sv
module vidctl_regbank_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        vblank;
    logic        draw_go, eng_init, frame_flip;
    logic [9:0]  vline_cmp_a, vline_cmp_b;

    localparam logic [31:0] ID_V   = 32'hC0DE_0017;
    localparam logic [31:0] REV_V  = 32'h0000_0203;
    localparam logic [31:0] BEAM_V = 32'h0123_0456;
    localparam logic [31:0] PPOS_V = 32'h00AB_CD00;
    localparam logic [31:0] LPOS_V = 32'h0055_AA10;

    always #4 clk = ~clk;

    vidctl_regbank #(.ADDR_W(5)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .id_val(ID_V), .rev_val(REV_V), .beam_val(BEAM_V),
        .prim_pos_val(PPOS_V), .link_pos_val(LPOS_V),
        .vblank(vblank), .draw_go(draw_go), .eng_init(eng_init),
        .frame_flip(frame_flip), .vline_cmp_a(vline_cmp_a), .vline_cmp_b(vline_cmp_b)
    );

    int n_tests = 0;
    int n_fail  = 0;

    // Scoreboard state.
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_req;
    logic [2:0]  pulse_nxt;
    string       pulse_tag;
    bit          pend_m;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares reads and pulses just after each edge.
    logic       s_req, s_rst;
    logic [2:0] s_pl;
    string      s_tag;
    always @(posedge clk) begin
        s_req = rd_req;
        s_rst = rst;
        s_pl  = pulse_nxt;
        s_tag = pulse_tag;
        #2;
        if (!s_rst) begin
            check({29'd0, draw_go, eng_init, frame_flip}, {29'd0, s_pl}, s_tag);
            if (s_req) begin
                if (exp_q.size() == 0) check(32'hBAD, 32'h0, "scoreboard empty");
                else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // Driver: one bus cycle with predicted results.
    task automatic step(input bit we, input logic [4:0] a, input logic [31:0] d,
                        input bit vb, input bit rd, input logic [31:0] exp, input string tag);
        bit dr, in, fl;
        dr = we && a == 5'd5 && d == 32'hFFFF_FFFF;
        in = we && a == 5'd6 && d[31];
        fl = we && a == 5'd7 && pend_m;
        if (fl) pend_m = 1'b0;
        else if (vb) pend_m = 1'b1;
        bus_we = we; bus_addr = a; bus_wdata = d; vblank = vb; rd_req = rd;
        pulse_nxt = {dr, in, fl};
        pulse_tag = tag;
        if (rd) begin exp_q.push_back(exp); tag_q.push_back(tag); end
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; vblank = 1'b0; rd_req = 1'b0; pulse_nxt = 3'b000;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 32'h0, tag);
    endtask

    task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
        step(1'b0, a, 32'h0, 1'b0, 1'b1, exp, tag);
    endtask

    initial begin
        #(200000 * 8);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; vblank = 1'b0;
        rd_req = 1'b0; pulse_nxt = 3'b000; pulse_tag = "R1 reset"; pend_m = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: cleared state after reset
        rd(5'd0,  ID_V,  "R1/R11 id after reset");
        rd(5'd8,  32'h0, "R1 window cleared");
        rd(5'd20, 32'h0, "R1 plain cleared");
        wr(5'd7, 32'h0000_1000, "R1 no flip after reset");
        check({22'd0, vline_cmp_a}, 32'h0, "R1 cmp a cleared");

        // R2: draw trigger
        wr(5'd5, 32'hFFFF_FFFF, "R2 draw magic");
        wr(5'd5, 32'hFFFF_FFFE, "R2 draw near miss");
        wr(5'd5, 32'h0000_0000, "R2 draw zero");
        rd(5'd5, 32'h0, "R2 trigger reads zero");

        // R3: init trigger
        wr(5'd6, 32'h8000_0000, "R3 init bit31");
        wr(5'd6, 32'h7FFF_FFFF, "R3 init no bit31");
        rd(5'd6, 32'h0, "R3 trigger reads zero");

        // R4: frame address mask
        wr(5'd7, 32'hFFFF_FFFF, "R4 fb write");
        rd(5'd7, 32'h00FF_FFFC, "R4 fb mask");

        // R5: interlock
        step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R5 arm");
        wr(5'd7, 32'h1234_5678, "R5 flip on pending");
        wr(5'd7, 32'h0000_0040, "R5 no second flip");
        step(1'b1, 5'd7, 32'h0000_0080, 1'b1, 1'b0, 32'h0, "R5 idle write+vblank no flip");
        wr(5'd7, 32'h0000_00C0, "R5 flip after same-cycle arm");
        step(1'b0, 5'd0, 32'h0, 1'b1, 1'b0, 32'h0, "R5 rearm");
        step(1'b1, 5'd7, 32'h0000_0100, 1'b1, 1'b0, 32'h0, "R5 clear wins over set");
        wr(5'd7, 32'h0000_0140, "R5 idle after clear wins");
        rd(5'd7, 32'h0000_0140, "R4 fb last value");

        // R6: window and IRQ position masks
        wr(5'd8, 32'hFFFF_FFFF, "R6 hwin");
        rd(5'd8, 32'h07FF_07FF, "R6 hwin mask");
        wr(5'd9, 32'hFFFF_FFFF, "R6 vwin");
        rd(5'd9, 32'h03FF_03FF, "R6 vwin mask");
        wr(5'd10, 32'hFFFF_FFFF, "R6 hirq");
        rd(5'd10, 32'h03FF_33FF, "R6 hirq mask");

        // R7: vertical IRQ outputs
        wr(5'd11, 32'hFFFF_FFFF, "R7 virq ones");
        check({22'd0, vline_cmp_a}, 32'h3FF, "R7 cmp a ones");
        check({22'd0, vline_cmp_b}, 32'h3FF, "R7 cmp b ones");
        wr(5'd11, 32'h1234_5678, "R7 virq pattern");
        rd(5'd11, 32'h0234_0278, "R7 virq mask");
        check({22'd0, vline_cmp_a}, 32'h234, "R7 cmp a pattern");
        check({22'd0, vline_cmp_b}, 32'h278, "R7 cmp b pattern");
        wr(5'd9, 32'h0, "R7 other write");
        check({22'd0, vline_cmp_b}, 32'h278, "R7 cmp b held");

        // R8 / R9: accelerator base and size masks
        for (int a = 12; a <= 14; a++) begin
            wr(5'(a), 32'hFFFF_FFFF, "R8 bin/link base");
            rd(5'(a), 32'h00FF_FFE0, "R8 bin/link mask");
        end
        for (int a = 15; a <= 16; a++) begin
            wr(5'(a), 32'hFFFF_FFFF, "R8 prim base");
            rd(5'(a), 32'h00FF_FFFC, "R8 prim mask");
        end
        wr(5'd17, 32'hFFFF_FFFF, "R9 dim");
        rd(5'd17, 32'h000F_003F, "R9 dim mask");
        wr(5'd18, 32'hFFFF_FFFF, "R9 cfg");
        rd(5'd18, 32'h0013_3333, "R9 cfg mask");

        // R10: plain storage
        wr(5'd19, 32'hDEAD_BEEF, "R10 plain low");
        wr(5'd31, 32'hA5A5_5A5A, "R10 plain high");
        rd(5'd19, 32'hDEAD_BEEF, "R10 plain low read");
        rd(5'd31, 32'hA5A5_5A5A, "R10 plain high read");

        // R11: status words ignore writes
        wr(5'd0, 32'h1111_1111, "R11 id write");
        wr(5'd2, 32'h2222_2222, "R11 beam write");
        rd(5'd0, ID_V,   "R11 id");
        rd(5'd1, REV_V,  "R11 rev");
        rd(5'd2, BEAM_V, "R11 beam");
        rd(5'd3, PPOS_V, "R11 prim pos");
        rd(5'd4, LPOS_V, "R11 link pos");

        // R12: same-edge write visible, back-to-back reads
        step(1'b1, 5'd20, 32'h0BAD_F00D, 1'b0, 1'b1, 32'h0BAD_F00D, "R12 write-through read");
        rd(5'd19, 32'hDEAD_BEEF, "R12 back-to-back a");
        rd(5'd20, 32'h0BAD_F00D, "R12 back-to-back b");

        // R1: reset clears again
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; pend_m = 1'b0;
        rd(5'd19, 32'h0, "R1 plain cleared again");
        check({22'd0, vline_cmp_a}, 32'h0, "R1 cmp a cleared again");

        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule